// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Timer

This block holds two independent, clock-synchronous one-shot timers. Each channel has three asynchronous control inputs: a falling-edge trigger, a rising-edge trigger and an active-low clear. It drives a pulse output and that output's complement. A qualified trigger loads a per-channel down-counter with a programmable length and raises the pulse output for that many clock cycles. A further trigger during the pulse reloads the counter, so a steady stream of triggers can hold the output high without limit. Driving the clear input low ends the pulse at once and blocks triggering. Releasing the clear input is itself a trigger source.

The control inputs pass through a two-stage synchroniser. Edges are then found by comparing the synchronised level with its value one clock earlier. Each channel's timer is a three-state machine:

- `ST_IDLE`: output low.
- `ST_PULSE`: output high, counter running.
- `ST_HOLD`: clear input is low.

The transitions are:

- **start**: IDLE to PULSE, on a trigger with a non-zero length.
- **retrigger**: PULSE to PULSE, with the counter reloaded.
- **expire**: PULSE to IDLE, when the count ends with no trigger.
- **zero-load**: PULSE to IDLE, on a trigger with a zero length.
- **clear**: any state to HOLD, while the clear input is low.
- **release**: HOLD to IDLE when clear goes high.
- **release-start**: HOLD to PULSE, when the clear input's rising edge is itself a qualified trigger.

Top module: `dual_oneshot`

## Requirements
- R1: The two channels are fully independent. Stimulus on one channel never changes the other channel's outputs.
- R2: A falling edge on `fall_trig_n[c]` starts a pulse only while `rise_trig[c]` and `clr_n[c]` are both high. Latency: `pulse_out[c]` rises at the third rising clock edge that samples the new input level. It then stays high for exactly L cycles, where L is the channel's length field.
- R3: A rising edge on `rise_trig[c]` starts a pulse only while `fall_trig_n[c]` is low and `clr_n[c]` is high. The latency and length are the same as in R2.
- R4: A rising edge on `clr_n[c]` starts a pulse when `fall_trig_n[c]` is low and `rise_trig[c]` is high.
- R5: A qualified trigger during a pulse reloads the counter. The output stays high until L cycles after the last trigger.
- R6: `clr_n[c]` low forces `pulse_out[c]` low at the third clock edge after the falling level is first sampled, whatever count remains.
- R7: While `clr_n[c]` is low, edges on the two trigger inputs start no pulse.
- R8: With a length field of zero, a trigger produces no pulse. A zero-length retrigger ends an active pulse.
- R9: A trigger that arrives in the last cycle of a pulse reloads the counter, and the output stays high with no gap.
- R10: `pulse_out_n[c]` is always the complement of `pulse_out[c]`.
- R11: A clock edge with `rst_n` low clears both timers and the edge history, leaving `pulse_out` low and `pulse_out_n` high. The history levels taken after reset are: falling trigger high, rising trigger low, clear high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| fall_trig_n | input | NUM_CH | Falling-edge trigger, one per channel |
| rise_trig | input | NUM_CH | Rising-edge trigger, one per channel |
| clr_n | input | NUM_CH | Active-low clear and trigger inhibit, one per channel |
| len_cfg | input | NUM_CH*CNT_W | Pulse length in cycles; channel c uses bits [c*CNT_W +: CNT_W] |
| pulse_out | output | NUM_CH | Active-high pulse output |
| pulse_out_n | output | NUM_CH | Complement of pulse_out |

## Verification
The hardest situation to reach is a retrigger that lands in exactly the cycle the counter would expire. Reaching it needs the trigger edge timed to the length, across the synchroniser delay. A directed phase produces it by pulsing the rising trigger at a period equal to the length, which keeps the output high only if the reload has no gap. A clear rising edge that qualifies as a trigger is also rare under random stimulus, so a directed phase sets up both trigger levels before releasing the clear input. Long random runs with small lengths then mix these cases with clears, zero lengths and system resets on both channels.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } os_state_t;

    typedef struct packed {
        logic fall_hit;
        logic rise_hit;
        logic clr_hit;
        logic fall_lvl;
        logic rise_lvl;
        logic clr_lvl;
    } edge_info_t;

endpackage

// File: rtl/oneshot_sync_edge.sv
module oneshot_sync_edge #(
    parameter bit RST_LVL     = 1'b0,
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic edge_seen
);

    logic s1_q;
    logic s2_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= RST_LVL;
            s2_q   <= RST_LVL;
            prev_q <= RST_LVL;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl = s2_q;

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_seen = s2_q & ~prev_q;
        end else begin : g_fall
            assign edge_seen = ~s2_q & prev_q;
        end
    endgenerate

endmodule

// File: rtl/oneshot_trig_gate.sv
module oneshot_trig_gate
    import oneshot_pkg::*;
(
    input  edge_info_t ei,
    output logic       trig,
    output logic       clr_ok
);

    logic fall_q;
    logic rise_q;
    logic clr_q;

    always_comb begin
        fall_q = ei.fall_hit & ei.rise_lvl & ei.clr_lvl;
        rise_q = ei.rise_hit & ~ei.fall_lvl & ei.clr_lvl;
        clr_q  = ei.clr_hit & ~ei.fall_lvl & ei.rise_lvl;
        trig   = fall_q | rise_q | clr_q;
        clr_ok = ei.clr_lvl;
    end

endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             clr_ok,
    input  logic [CNT_W-1:0] load_len,
    output logic             q_o,
    output logic             qn_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    os_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             len_nz;

    assign len_nz = (load_len != CNT_ZERO);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clr_ok) begin
                    state_d = ST_HOLD;
                end else if (trig && len_nz) begin
                    state_d = ST_PULSE;
                    cnt_d   = load_len;
                end
            end
            ST_PULSE: begin
                if (!clr_ok) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_ZERO;
                end else if (trig) begin
                    if (len_nz) begin
                        cnt_d = load_len;
                    end else begin
                        state_d = ST_IDLE;
                        cnt_d   = CNT_ZERO;
                    end
                end else if (cnt_q == CNT_ONE) begin
                    state_d = ST_IDLE;
                    cnt_d   = CNT_ZERO;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_HOLD: begin
                if (clr_ok) begin
                    if (trig && len_nz) begin
                        state_d = ST_PULSE;
                        cnt_d   = load_len;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = CNT_ZERO;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        q_o  = (state_q == ST_PULSE);
        qn_o = ~q_o;
    end

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ok |=> !q_o);

    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && trig && len_nz) |=> (q_o && cnt_q == $past(load_len)));

    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !len_nz) |=> !q_o);

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_ok && !trig && cnt_q > CNT_ONE) |=> (q_o && cnt_q == $past(cnt_q) - CNT_ONE));

    a_r9_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_ok && !trig && cnt_q == CNT_ONE) |=> !q_o);

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
    import oneshot_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       fall_trig_n,
    input  logic [NUM_CH-1:0]       rise_trig,
    input  logic [NUM_CH-1:0]       clr_n,
    input  logic [NUM_CH*CNT_W-1:0] len_cfg,
    output logic [NUM_CH-1:0]       pulse_out,
    output logic [NUM_CH-1:0]       pulse_out_n
);

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            edge_info_t ei;
            logic       trig;
            logic       clr_ok;

            oneshot_sync_edge #(.RST_LVL(1'b1), .DETECT_RISE(1'b0)) u_fall (
                .clk       (clk),
                .rst_n     (rst_n),
                .din       (fall_trig_n[ch]),
                .lvl       (ei.fall_lvl),
                .edge_seen (ei.fall_hit)
            );

            oneshot_sync_edge #(.RST_LVL(1'b0), .DETECT_RISE(1'b1)) u_rise (
                .clk       (clk),
                .rst_n     (rst_n),
                .din       (rise_trig[ch]),
                .lvl       (ei.rise_lvl),
                .edge_seen (ei.rise_hit)
            );

            oneshot_sync_edge #(.RST_LVL(1'b1), .DETECT_RISE(1'b1)) u_clr (
                .clk       (clk),
                .rst_n     (rst_n),
                .din       (clr_n[ch]),
                .lvl       (ei.clr_lvl),
                .edge_seen (ei.clr_hit)
            );

            oneshot_trig_gate u_gate (
                .ei     (ei),
                .trig   (trig),
                .clr_ok (clr_ok)
            );

            oneshot_pulse_timer #(.CNT_W(CNT_W)) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .trig     (trig),
                .clr_ok   (clr_ok),
                .load_len (len_cfg[ch*CNT_W +: CNT_W]),
                .q_o      (pulse_out[ch]),
                .qn_o     (pulse_out_n[ch])
            );
        end
    endgenerate

    a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out ^ pulse_out_n) == {NUM_CH{1'b1}});

endmodule

// File: tb/dual_oneshot_tb.sv
module dual_oneshot_tb_top;

    localparam int NCH = 2;
    localparam int CW  = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  fall_trig_n;
    logic [NCH-1:0]  rise_trig;
    logic [NCH-1:0]  clr_n;
    logic [NCH*CW-1:0] len_cfg;
    logic [NCH-1:0]  pulse_out;
    logic [NCH-1:0]  pulse_out_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dual_oneshot #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_trig_n (fall_trig_n),
        .rise_trig   (rise_trig),
        .clr_n       (clr_n),
        .len_cfg     (len_cfg),
        .pulse_out   (pulse_out),
        .pulse_out_n (pulse_out_n)
    );

    bit a1[NCH], a2[NCH], ap[NCH];
    bit b1[NCH], b2[NCH], bp[NCH];
    bit r1[NCH], r2[NCH], rp[NCH];
    int mst[NCH];
    int mcnt[NCH];

    function automatic bit gate_fn(bit fa2, bit fap, bit rb2, bit rbp, bit cr2, bit crp);
        return (fap & ~fa2 & rb2 & cr2) | (~rbp & rb2 & ~fa2 & cr2) | (~crp & cr2 & ~fa2 & rb2);
    endfunction

    function automatic int len_of(int c);
        return int'(len_cfg[c*CW +: CW]);
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                a1[c] = 1; a2[c] = 1; ap[c] = 1;
                b1[c] = 0; b2[c] = 0; bp[c] = 0;
                r1[c] = 1; r2[c] = 1; rp[c] = 1;
                mst[c] = 0; mcnt[c] = 0;
            end else begin
                bit t;
                int l;
                t = gate_fn(a2[c], ap[c], b2[c], bp[c], r2[c], rp[c]);
                l = len_of(c);
                if (!r2[c]) begin
                    mst[c] = 2; mcnt[c] = 0;
                end else if (t) begin
                    if (l != 0) begin mst[c] = 1; mcnt[c] = l; end
                    else begin mst[c] = 0; mcnt[c] = 0; end
                end else if (mst[c] == 1) begin
                    if (mcnt[c] == 1) begin mst[c] = 0; mcnt[c] = 0; end
                    else mcnt[c] = mcnt[c] - 1;
                end else begin
                    mst[c] = 0;
                end
                ap[c] = a2[c]; a2[c] = a1[c]; a1[c] = fall_trig_n[c];
                bp[c] = b2[c]; b2[c] = b1[c]; b1[c] = rise_trig[c];
                rp[c] = r2[c]; r2[c] = r1[c]; r1[c] = clr_n[c];
            end
        end
    end

    task automatic step(input string tag);
        @(negedge clk);
        cycles++;
        for (int c = 0; c < NCH; c++) begin
            bit exp_q;
            exp_q = (mst[c] == 1);
            checks++;
            if (pulse_out[c] !== exp_q) begin
                errors++;
                $display("FAIL %s ch%0d pulse_out actual=%b expected=%b at cycle %0d",
                         tag, c, pulse_out[c], exp_q, cycles);
            end
            checks++;
            if (pulse_out_n[c] !== ~exp_q) begin
                errors++;
                $display("FAIL R10 ch%0d pulse_out_n actual=%b expected=%b at cycle %0d",
                         c, pulse_out_n[c], ~exp_q, cycles);
            end
        end
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        fall_trig_n = '1;
        rise_trig = '0;
        clr_n = '1;
        len_cfg = {8'd3, 8'd5};
        @(posedge clk);
        steps(4, "R11");
        rst_n = 1'b1;
        steps(3, "R11");

        // R2: rising edge on rise_trig with fall_trig_n high does not fire; then fall edge fires
        rise_trig[0] = 1'b1;
        steps(5, "R3");
        fall_trig_n[0] = 1'b0;
        steps(10, "R2");
        fall_trig_n[0] = 1'b1;
        rise_trig[0] = 1'b0;
        steps(3, "R2");
        // R2: fall edge with rise_trig low is gated off
        fall_trig_n[0] = 1'b0;
        steps(6, "R2");

        // R3: rise edge with fall_trig_n low fires
        rise_trig[0] = 1'b1;
        steps(3, "R3");
        // R1: channel 1 fires while channel 0 pulses
        rise_trig[1] = 1'b1;
        fall_trig_n[1] = 1'b1;
        steps(2, "R1");
        fall_trig_n[1] = 1'b0;
        steps(8, "R1");

        // R5: repeated rise edges stretch the pulse
        for (int k = 0; k < 6; k++) begin
            rise_trig[0] = 1'b0;
            steps(2, "R5");
            rise_trig[0] = 1'b1;
            steps(2, "R5");
        end
        steps(8, "R5");

        // R9: retrigger period equal to length (4)
        len_cfg[7:0] = 8'd4;
        rise_trig[0] = 1'b0;
        steps(3, "R9");
        for (int k = 0; k < 8; k++) begin
            rise_trig[0] = 1'b1;
            step("R9");
            rise_trig[0] = 1'b0;
            steps(3, "R9");
        end
        steps(6, "R9");

        // R6: clear ends a long pulse early
        len_cfg[7:0] = 8'd40;
        rise_trig[0] = 1'b1;
        steps(6, "R6");
        clr_n[0] = 1'b0;
        steps(6, "R6");

        // R7: triggers ignored while clear is low
        for (int k = 0; k < 4; k++) begin
            rise_trig[0] = 1'b0; fall_trig_n[0] = 1'b1;
            steps(2, "R7");
            rise_trig[0] = 1'b1;
            steps(2, "R7");
            fall_trig_n[0] = 1'b0;
            steps(2, "R7");
        end

        // R4: clear release with fall low and rise high fires
        len_cfg[7:0] = 8'd6;
        clr_n[0] = 1'b1;
        steps(12, "R4");

        // R8: zero length produces no pulse and ends an active pulse
        len_cfg[7:0] = 8'd0;
        rise_trig[0] = 1'b0;
        steps(2, "R8");
        rise_trig[0] = 1'b1;
        steps(6, "R8");
        len_cfg[7:0] = 8'd20;
        rise_trig[0] = 1'b0;
        steps(2, "R8");
        rise_trig[0] = 1'b1;
        steps(6, "R8");
        len_cfg[7:0] = 8'd0;
        rise_trig[0] = 1'b0;
        steps(2, "R8");
        rise_trig[0] = 1'b1;
        steps(6, "R8");

        // R11: system reset in the middle of a pulse
        len_cfg[7:0] = 8'd30;
        rise_trig[0] = 1'b0;
        steps(2, "R11");
        rise_trig[0] = 1'b1;
        steps(5, "R11");
        rise_trig = '0; fall_trig_n = '1; clr_n = '1;
        rst_n = 1'b0;
        steps(3, "R11");
        rst_n = 1'b1;
        steps(3, "R11");

        // R1: constrained random on both channels
        for (int i = 0; i < 6000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(7) == 0) fall_trig_n[c] = ~fall_trig_n[c];
                if ($urandom_range(7) == 0) rise_trig[c] = ~rise_trig[c];
                if ($urandom_range(19) == 0) clr_n[c] = ~clr_n[c];
                if ($urandom_range(31) == 0) len_cfg[c*CW +: CW] = CW'($urandom_range(7));
            end
            if ($urandom_range(499) == 0) begin
                rst_n = 1'b0;
                rise_trig = '0; fall_trig_n = '1; clr_n = '1;
            end else begin
                rst_n = 1'b1;
            end
            step("R1");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule